// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM read or write burst. A one-cycle start strobe loads a start column together with a burst length code and an ordering type. From the next cycle on, the block presents one column address per clock with a valid flag. It stops after the programmed number of beats, when a terminate strobe arrives, or never in page mode. A done pulse marks the final beat of a counted burst.

Two orderings are supported. Sequential ordering counts upward and wraps inside the aligned window of the burst length. Interleaved ordering XORs the start column's low bits with the beat number. Page mode is sequential only and runs round the whole row of columns until it is stopped. A new start strobe on any cycle abandons the current burst and begins the new one at once. Mode inputs are captured at the start strobe, so the command decoder may change them freely while a burst runs.

Top module: `sdram_burst_colgen`

## Requirements
- R1: During and right after reset, valid_o and done_o are 0.
- R2: In the cycle after start_i is sampled high, valid_o is 1 and col_o equals the start_col_i value captured with it.
- R3: len_code_i selects the beat count N: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives page mode, and the unused codes 4, 5 and 6 give 1. A counted burst keeps valid_o high for exactly N consecutive cycles, after which valid_o is 0.
- R4: With ilv_i = 0, beat k (counting from 0) has col_o = (S & ~(N-1)) | ((S + k) & (N-1)), where S is the start column. Bits above the window never change.
- R5: With ilv_i = 1, beat k has col_o = (S & ~(N-1)) | ((S ^ k) & (N-1)).
- R6: Page mode with ilv_i = 0 gives col_o = (S + k) mod 512, wraps from 511 to 0, and stays valid until it is stopped or restarted.
- R7: Page mode code 7 with ilv_i = 1 behaves as an interleaved burst of 8.
- R8: done_o is 1 only on the final beat of a counted burst, always together with valid_o. It is never 1 in page mode.
- R9: stop_i sampled high with start_i low makes valid_o 0 from the next cycle. A stop while idle has no effect.
- R10: start_i sampled during a burst restarts at the new start column with the new mode. start_i wins over stop_i sampled in the same cycle.
- R11: Changes to start_col_i, len_code_i or ilv_i while start_i is low do not alter a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a burst; one cycle per command |
| start_col_i | input | 9 | Start column, captured with start_i |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 0 sequential, 1 interleaved ordering |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a live beat |
| done_o | output | 1 | Current beat is the last of a counted burst |

## Verification
The assertions are evaluated on every cycle and cover the following:
- the load of the start column and a zero beat count after a start,
- the beat count never leaving the burst window,
- column bits above the window matching the captured start,
- the captured mode staying stable through a burst,
- the burst ending after done or after a stop,
- page mode never appearing with interleaved ordering.

The exact address order is shown only by the bench's scenarios. These cover each length and ordering from aligned and unaligned starts, the 511-to-0 page wrap, the remapped interleaved page code, and restarts and stops placed mid-burst.

// File: rtl/colgen_pkg.sv
// Shared definitions for the burst column sequencer.
// Assumes length codes are 3 bits wide; unused codes fall back to one beat.
package colgen_pkg;
    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    // log2 of the beat count used when interleaved page mode is requested
    localparam int unsigned ILV_PAGE_LG = 3;
endpackage

// File: rtl/colgen_mode_dec.sv
// Decodes a burst length code and ordering into a window mask and a
// page-mode flag. Purely combinational. Assumes COL_W >= 3.
module colgen_mode_dec
    import colgen_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    localparam int unsigned LG_W = $clog2(COL_W + 1);

    logic [LG_W-1:0] lg;
    logic [COL_W:0]  span;

    // map the code to log2 of the beat count and the page flag
    always_comb begin
        page_o = 1'b0;
        case (len_code_e'(len_code_i))
            LEN_1:    lg = '0;
            LEN_2:    lg = LG_W'(1);
            LEN_4:    lg = LG_W'(2);
            LEN_8:    lg = LG_W'(3);
            LEN_PAGE: begin
                if (ilv_i) begin
                    lg = LG_W'(ILV_PAGE_LG);
                end else begin
                    lg     = LG_W'(COL_W);
                    page_o = 1'b1;
                end
            end
            default:  lg = '0;
        endcase
    end

    // window mask is beat count minus one; a full row wraps to all ones
    always_comb begin
        span   = (COL_W+1)'(1) << lg;
        mask_o = COL_W'(span - (COL_W+1)'(1));
    end

    // page mode is only produced for sequential ordering
    // R7
    always_comb begin
        ilv_page_chk: assert (!(page_o && ilv_i));
    end
endmodule

// File: rtl/colgen_beat_ctr.sv
// Holds the captured burst mode and start column and counts beats.
// Assumes start_i and stop_i are single-cycle strobes sampled on clk;
// start has priority over stop.
module colgen_beat_ctr #(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    input  logic             ilv_i,
    output logic             active_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             done_o
);
    logic             active_q;
    logic             page_q;
    logic             ilv_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;

    // final beat of a counted burst
    always_comb begin
        done_o = active_q && !page_q && (cnt_q == mask_q);
    end

    // burst state: load on start, clear on stop or end, else advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            page_q   <= 1'b0;
            ilv_q    <= 1'b0;
            cnt_q    <= '0;
            base_q   <= '0;
            mask_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            page_q   <= page_i;
            ilv_q    <= ilv_i;
            cnt_q    <= '0;
            base_q   <= col_i;
            mask_q   <= mask_i;
        end else if (stop_i || done_o) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + COL_W'(1);
        end
    end

    assign active_o = active_q;
    assign cnt_o    = cnt_q;
    assign base_o   = base_q;
    assign mask_o   = mask_q;
    assign ilv_o    = ilv_q;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_q && cnt_q == '0));
    // R3
    cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> ((cnt_q & ~mask_q) == '0));
    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !active_q);
    // R9
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !active_q);
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(mask_q) && $stable(base_q) && $stable(ilv_q)));
endmodule

// File: rtl/colgen_addr_map.sv
// Forms the column address from the captured start, the beat count and
// the window mask: bits inside the window take the ordered offset, bits
// above it keep the start column. Combinational; clk/rst_n serve checks.
module colgen_addr_map #(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] offs;

    // ordered offset: XOR for interleaved, add for sequential
    always_comb begin
        offs = ilv_i ? (base_i ^ cnt_i) : (base_i + cnt_i);
    end

    // per-bit select between offset and start column
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? offs[b] : base_i[b];
    end

    // R4
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (((col_o ^ base_i) & ~mask_i) == '0));
endmodule

// File: rtl/sdram_burst_colgen.sv
// Burst column address sequencer: turns a start strobe, start column and
// length/order mode into one column address per clock until the burst
// ends, is stopped, or is replaced. Synchronous active-low reset.
module sdram_burst_colgen #(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             done_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             act;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    logic             ilv_cap;

    colgen_mode_dec #(.COL_W(COL_W)) u_dec (
        .len_code_i (len_code_i),
        .ilv_i      (ilv_i),
        .mask_o     (dec_mask),
        .page_o     (dec_page)
    );

    colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .col_i    (start_col_i),
        .mask_i   (dec_mask),
        .page_i   (dec_page),
        .ilv_i    (ilv_i),
        .active_o (act),
        .cnt_o    (cnt),
        .base_o   (base),
        .mask_o   (mask),
        .ilv_o    (ilv_cap),
        .done_o   (done_o)
    );

    colgen_addr_map #(.COL_W(COL_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (act),
        .base_i   (base),
        .cnt_i    (cnt),
        .mask_i   (mask),
        .ilv_i    (ilv_cap),
        .col_o    (col_o)
    );

    assign valid_o = act;

    // R8
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);
endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             done_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // beat count from the length code (R3, R7); 512 stands for page mode
    function automatic int beats(input int code, input bit ilv);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return ilv ? 8 : 512;
            default: return 1;
        endcase
    endfunction

    // expected address of beat k (R4, R5, R6)
    function automatic int exp_col(input int s, input int n, input bit ilv, input int k);
        int m   = n - 1;
        int low = ilv ? (s ^ k) : (s + k);
        return ((s & ~m) | (low & m)) & 511;
    endfunction

    task automatic issue(input int s, input int code, input bit ilv);
        start_i = 1'b1; start_col_i = s[COL_W-1:0];
        len_code_i = code[2:0]; ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // counted burst checked beat by beat; mode inputs scrambled mid-burst (R11)
    task automatic t_burst(input int s, input int code, input bit ilv, input string req);
        int n = beats(code, ilv);
        issue(s, code, ilv);
        for (int k = 0; k < n; k++) begin
            check({req, " col"}, col_o, exp_col(s, n, ilv, k));
            check({req, " R3 valid"}, valid_o, 1);
            check({req, " R8 done"}, done_o, (k == n - 1) ? 1 : 0);
            start_col_i = ~start_col_i; len_code_i = 3'd7; ilv_i = ~ilv_i;
            @(negedge clk);
        end
        check({req, " R3 end"}, valid_o, 0);
        check({req, " R8 done low"}, done_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 valid", valid_o, 0);
        check("R1 done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after", valid_o, 0);
    endtask

    task automatic t_page_wrap();
        int s = 9'h1FC;
        issue(s, 7, 1'b0);
        for (int k = 0; k < 520; k++) begin
            check("R6 col", col_o, (s + k) & 511);
            check("R6 valid", valid_o, 1);
            check("R8 page done", done_o, 0);
            @(negedge clk);
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R9 stop page", valid_o, 0);
    endtask

    task automatic t_stop();
        issue(9'h040, 3, 1'b0);
        check("R9 pre col", col_o, 9'h040);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R9 stopped", valid_o, 0);
        @(negedge clk);
        check("R9 stays off", valid_o, 0);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R9 idle stop", valid_o, 0);
        issue(9'h011, 1, 1'b0);
        check("R9 start after stop", col_o, 9'h011);
        check("R9 valid after stop", valid_o, 1);
        @(negedge clk);
        @(negedge clk);
        check("R9 ends", valid_o, 0);
    endtask

    task automatic t_restart();
        issue(9'h100, 3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R10 mid col", col_o, 9'h102);
        stop_i = 1'b1;
        issue(9'h0A5, 2, 1'b1);
        stop_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R10 restart col", col_o, exp_col(9'h0A5, 4, 1'b1, k));
            check("R10 restart valid", valid_o, 1);
            @(negedge clk);
        end
        check("R10 restart end", valid_o, 0);
    endtask

    initial begin
        int starts[4] = '{0, 9'h0A5, 9'h1FF, 9'h013};
        @(negedge clk);
        t_reset();
        foreach (starts[i]) begin
            for (int c = 0; c < 4; c++) begin
                t_burst(starts[i], c, 1'b0, "R4");
                t_burst(starts[i], c, 1'b1, "R5");
            end
        end
        t_burst(9'h0C6, 7, 1'b1, "R7");
        t_burst(9'h03B, 7, 1'b1, "R7");
        t_burst(9'h07D, 5, 1'b0, "R3 code5");
        t_burst(9'h07D, 4, 1'b1, "R3 code4");
        t_burst(9'h0E1, 6, 1'b0, "R3 code6");
        t_burst(9'h12E, 1, 1'b0, "R2");
        t_page_wrap();
        t_stop();
        t_restart();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule